// File: doc/BRIEF.md
# Sleep Depth Selection Controller

This block decides how deeply the system sleeps while the processor is halted. It orders four sleep states from shallow to deep: IDLE (core clock stopped, peripheral clocks kept), STOP (most clocks stopped), STANDBY (major blocks power-gated) and OFF (all internal power removed). For each state it drives three control enables and a state code. The clock and power hardware sits outside the block. The controller reaches it through a request/acknowledge pair when a power-gated state is entered.

The block has two ways of choosing a state. In timeout mode it starts at IDLE and goes one level deeper each time the idle period outlasts the programmed dwell time of the current level. In predictive mode the processor gives a hint: the number of always-on cycles until the next expected event. The controller then goes straight to the deepest state whose programmed wake latency fits inside that hint, and it stays there.

Which wake sources are honoured depends on the state. Enabled interrupt lines and the low-frequency timer wake the block from IDLE, STOP and STANDBY. The dedicated external wake input works from every state, and it is the only source that works from OFF. Each exit raises a wake-in-progress flag for the latency of the state being left.

Top module: `sleep_ctl`

## Requirements
- R1: After synchronous reset, state_o is 0 (ACTIVE) and core_clk_stop_o, main_clk_stop_o, pwr_gate_req_o and wake_busy_o are all low.
- R2: state_o encodes ACTIVE=0, IDLE=1, STOP=2, STANDBY=3, OFF=4. core_clk_stop_o is high in every state other than ACTIVE. main_clk_stop_o is high in STOP, STANDBY and OFF. pwr_gate_req_o is high in STANDBY and OFF, and also while an entry into a power-gated state waits for its acknowledge.
- R3: In timeout mode (pred_mode_i low, or hint_valid_i low), when cpu_idle_i is sampled high in ACTIVE and wake_busy_o is low, state_o becomes IDLE on the next clock edge.
- R4: tmo_cfg_i holds one dwell field per level, CNT_W bits each: field 0 (lowest bits) for IDLE, field 1 for STOP, field 2 for STANDBY. In timeout mode each of these states is shown for exactly that many cycles (a value of 0 acts as 1) and then moves exactly one level deeper. OFF never deepens.
- R5: A move into STANDBY or OFF first raises pwr_gate_req_o while state_o keeps its old value. The new state appears on the edge after pg_ack_i is sampled high. The dwell timer is frozen while the controller waits.
- R6: With pred_mode_i and hint_valid_i high, idle entry from ACTIVE picks the deepest state k whose latency field in lat_cfg_i (CNT_W bits each; field 0 is IDLE, 1 is STOP, 2 is STANDBY, 3 is OFF) is less than or equal to hint_cycles_i. If no state fits, the controller stays ACTIVE. A state entered this way never deepens by timeout.
- R7: In IDLE, STOP or STANDBY, any of the following returns state_o to ACTIVE on the next edge and cancels any pending gated entry: an interrupt line that is high and enabled in irq_en_i, tmr_wake_i, or ext_wake_i.
- R8: In OFF, irq_i and tmr_wake_i are ignored. Only ext_wake_i returns the controller to ACTIVE, on the next edge.
- R9: Interrupt lines whose irq_en_i bit is low neither wake the controller nor restart the dwell timer, so the next deepening step happens on its original cycle.
- R10: On every exit from a sleep state, wake_busy_o is high for exactly the latency field of the state left, starting with the first ACTIVE cycle. No sleep entry is started while it is high.
- R11: When cpu_idle_i is sampled low in a sleep state, state_o returns to ACTIVE on the next edge and counts as an exit (R10). When cpu_idle_i is sampled low while a gated entry from ACTIVE is pending, the request is withdrawn and wake_busy_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_idle_i | input | 1 | Processor idle indication |
| pred_mode_i | input | 1 | Selects predictive entry when a hint is valid |
| hint_valid_i | input | 1 | Qualifies hint_cycles_i |
| hint_cycles_i | input | CNT_W | Expected cycles until the next event |
| tmo_cfg_i | input | 3*CNT_W | Dwell times for IDLE, STOP, STANDBY |
| lat_cfg_i | input | 4*CNT_W | Wake latencies for IDLE, STOP, STANDBY, OFF |
| irq_i | input | N_IRQ | External interrupt lines |
| irq_en_i | input | N_IRQ | Per-line interrupt wake enable |
| tmr_wake_i | input | 1 | Low-frequency timer wake event |
| ext_wake_i | input | 1 | Dedicated external wake input |
| pg_ack_i | input | 1 | Power switch acknowledge for gated entry |
| state_o | output | 3 | Current state code |
| core_clk_stop_o | output | 1 | Stop the core clock |
| main_clk_stop_o | output | 1 | Stop the main clocks |
| pwr_gate_req_o | output | 1 | Power-gate request for the switched domain |
| wake_busy_o | output | 1 | Wake in progress |

## Verification
Some rules hold on every cycle, and the assertions check those. A sleep state only ever steps one level deeper. A power-gated state is never entered without an acknowledge. The external wake and a dropped idle indication always exit in one cycle. Entry is held off while a wake is in progress. The main clocks never stop unless the core clock is stopped too. Other rules depend on programmed values, and only the bench scenarios can show them. These are the exact dwell cycle counts, the choice of the deepest state that fits a hint, the equal-latency boundary, the masking of disabled interrupt lines without a timer restart, and the length of the wake-busy window.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

    localparam int N_LVL = 4;           // sleep levels below ACTIVE
    localparam int N_TMO = N_LVL - 1;   // levels that can deepen

    typedef enum logic [2:0] {
        PS_ACTIVE  = 3'd0,
        PS_IDLE    = 3'd1,
        PS_STOP    = 3'd2,
        PS_STANDBY = 3'd3,
        PS_OFF     = 3'd4
    } pstate_e;

    typedef struct packed {
        logic core_stop;
        logic clk_stop;
        logic pgate;
    } ctl_s;

    typedef struct packed {
        logic irq;
        logic tmr;
        logic ext;
    } wake_mask_s;

    function automatic ctl_s ctl_of(pstate_e s);
        ctl_s c;
        c.core_stop = (s != PS_ACTIVE);
        c.clk_stop  = (s == PS_STOP) || (s == PS_STANDBY) || (s == PS_OFF);
        c.pgate     = (s == PS_STANDBY) || (s == PS_OFF);
        return c;
    endfunction

    function automatic logic is_gated(pstate_e s);
        return (s == PS_STANDBY) || (s == PS_OFF);
    endfunction

    function automatic pstate_e deeper(pstate_e s);
        case (s)
            PS_IDLE:    return PS_STOP;
            PS_STOP:    return PS_STANDBY;
            default:    return PS_OFF;
        endcase
    endfunction

    function automatic logic [1:0] lvl_of(pstate_e s);
        case (s)
            PS_STOP:    return 2'd1;
            PS_STANDBY: return 2'd2;
            PS_OFF:     return 2'd3;
            default:    return 2'd0;
        endcase
    endfunction

    function automatic wake_mask_s wake_allow(pstate_e s);
        wake_mask_s m;
        case (s)
            PS_IDLE, PS_STOP, PS_STANDBY: m = '{irq: 1'b1, tmr: 1'b1, ext: 1'b1};
            PS_OFF:                       m = '{irq: 1'b0, tmr: 1'b0, ext: 1'b1};
            default:                      m = '{irq: 1'b0, tmr: 1'b0, ext: 1'b0};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sleep_depth_pick.sv
module sleep_depth_pick
    import sleep_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0]       hint_i,
    input  logic [N_LVL*CNT_W-1:0] lat_flat_i,
    output logic                   fit_any_o,
    output pstate_e                fit_state_o
);

    logic [N_LVL-1:0] fits;

    generate
        for (genvar k = 0; k < N_LVL; k++) begin : g_cmp
            assign fits[k] = (lat_flat_i[k*CNT_W +: CNT_W] <= hint_i);
        end
    endgenerate

    // ascending scan: the deepest fitting level wins
    always_comb begin
        fit_state_o = PS_ACTIVE;
        for (int k = 0; k < N_LVL; k++) begin
            if (fits[k]) fit_state_o = pstate_e'(3'(k + 1));
        end
    end

    assign fit_any_o = |fits;

endmodule

// File: rtl/sleep_wake_filter.sv
module sleep_wake_filter
    import sleep_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  pstate_e          state_i,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic [N_IRQ-1:0] irq_en_i,
    input  logic             tmr_i,
    input  logic             ext_i,
    output logic             accept_o
);

    wake_mask_s allow;
    logic       irq_hit;

    assign allow    = wake_allow(state_i);
    assign irq_hit  = |(irq_i & irq_en_i);
    assign accept_o = (allow.irq & irq_hit) | (allow.tmr & tmr_i) | (allow.ext & ext_i);

endmodule

// File: rtl/sleep_dwell_timer.sv
module sleep_dwell_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // a limit of zero behaves as one cycle
    assign expired_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};

endmodule

// File: rtl/sleep_wake_timer.sv
module sleep_wake_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             busy_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl
    import sleep_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_IRQ = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cpu_idle_i,
    input  logic                   pred_mode_i,
    input  logic                   hint_valid_i,
    input  logic [CNT_W-1:0]       hint_cycles_i,
    input  logic [N_TMO*CNT_W-1:0] tmo_cfg_i,
    input  logic [N_LVL*CNT_W-1:0] lat_cfg_i,
    input  logic [N_IRQ-1:0]       irq_i,
    input  logic [N_IRQ-1:0]       irq_en_i,
    input  logic                   tmr_wake_i,
    input  logic                   ext_wake_i,
    input  logic                   pg_ack_i,
    output logic [2:0]             state_o,
    output logic                   core_clk_stop_o,
    output logic                   main_clk_stop_o,
    output logic                   pwr_gate_req_o,
    output logic                   wake_busy_o
);

    logic [CNT_W-1:0] tmo_arr [N_TMO];
    logic [CNT_W-1:0] lat_arr [N_LVL];

    generate
        for (genvar i = 0; i < N_TMO; i++) begin : g_tmo
            assign tmo_arr[i] = tmo_cfg_i[i*CNT_W +: CNT_W];
        end
        for (genvar i = 0; i < N_LVL; i++) begin : g_lat
            assign lat_arr[i] = lat_cfg_i[i*CNT_W +: CNT_W];
        end
    endgenerate

    pstate_e state_q, state_d;
    pstate_e tgt_q,   tgt_d;
    pstate_e ceil_q,  ceil_d;
    logic    pend_q,  pend_d;

    logic             fit_any;
    pstate_e          fit_state;
    logic             wake_acc;
    logic             dwell_exp;
    logic             dwell_clr;
    logic [CNT_W-1:0] dwell_lim;
    logic             wk_load;
    logic [CNT_W-1:0] wk_lat;
    logic             wk_busy;
    logic             pred_sel;
    pstate_e          entry_tgt;
    logic             entry_ok;
    ctl_s             ctl;

    sleep_depth_pick #(.CNT_W(CNT_W)) u_pick (
        .hint_i      (hint_cycles_i),
        .lat_flat_i  (lat_cfg_i),
        .fit_any_o   (fit_any),
        .fit_state_o (fit_state)
    );

    sleep_wake_filter #(.N_IRQ(N_IRQ)) u_wake (
        .state_i  (state_q),
        .irq_i    (irq_i),
        .irq_en_i (irq_en_i),
        .tmr_i    (tmr_wake_i),
        .ext_i    (ext_wake_i),
        .accept_o (wake_acc)
    );

    always_comb begin
        case (state_q)
            PS_IDLE:    dwell_lim = tmo_arr[0];
            PS_STOP:    dwell_lim = tmo_arr[1];
            PS_STANDBY: dwell_lim = tmo_arr[2];
            default:    dwell_lim = '1;
        endcase
    end

    sleep_dwell_timer #(.CNT_W(CNT_W)) u_dwell (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (dwell_clr),
        .run_i     ((state_q != PS_ACTIVE) && !pend_q),
        .limit_i   (dwell_lim),
        .expired_o (dwell_exp)
    );

    sleep_wake_timer #(.CNT_W(CNT_W)) u_wkt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (wk_load),
        .load_val_i (wk_lat),
        .busy_o     (wk_busy)
    );

    // entry choice out of ACTIVE
    assign pred_sel  = pred_mode_i && hint_valid_i;
    assign entry_ok  = pred_sel ? fit_any : 1'b1;
    assign entry_tgt = pred_sel ? fit_state : PS_IDLE;

    always_comb begin
        state_d   = state_q;
        tgt_d     = tgt_q;
        ceil_d    = ceil_q;
        pend_d    = pend_q;
        dwell_clr = 1'b0;
        wk_load   = 1'b0;
        wk_lat    = '0;
        if (state_q == PS_ACTIVE) begin
            if (pend_q) begin
                if (!cpu_idle_i) begin
                    pend_d = 1'b0;
                end else if (pg_ack_i) begin
                    state_d   = tgt_q;
                    pend_d    = 1'b0;
                    dwell_clr = 1'b1;
                end
            end else if (cpu_idle_i && !wk_busy && entry_ok) begin
                ceil_d = pred_sel ? fit_state : PS_OFF;
                if (is_gated(entry_tgt)) begin
                    pend_d = 1'b1;
                    tgt_d  = entry_tgt;
                end else begin
                    state_d   = entry_tgt;
                    dwell_clr = 1'b1;
                end
            end
        end else begin
            if (wake_acc || !cpu_idle_i) begin
                state_d   = PS_ACTIVE;
                pend_d    = 1'b0;
                dwell_clr = 1'b1;
                wk_load   = 1'b1;
                wk_lat    = lat_arr[lvl_of(state_q)];
            end else if (pend_q) begin
                if (pg_ack_i) begin
                    state_d   = tgt_q;
                    pend_d    = 1'b0;
                    dwell_clr = 1'b1;
                end
            end else if (dwell_exp && (state_q != ceil_q)) begin
                if (is_gated(deeper(state_q))) begin
                    pend_d = 1'b1;
                    tgt_d  = deeper(state_q);
                end else begin
                    state_d   = deeper(state_q);
                    dwell_clr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_ACTIVE;
            tgt_q   <= PS_ACTIVE;
            ceil_q  <= PS_OFF;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
            ceil_q  <= ceil_d;
            pend_q  <= pend_d;
        end
    end

    assign ctl             = ctl_of(state_q);
    assign state_o         = state_q;
    assign core_clk_stop_o = ctl.core_stop;
    assign main_clk_stop_o = ctl.clk_stop;
    assign pwr_gate_req_o  = ctl.pgate | pend_q;
    assign wake_busy_o     = wk_busy;

endmodule

// File: rtl/sleep_ctl_chk.sv
module sleep_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cpu_idle_i,
    input logic       ext_wake_i,
    input logic       pg_ack_i,
    input logic [2:0] state_o,
    input logic       core_clk_stop_o,
    input logic       main_clk_stop_o,
    input logic       wake_busy_o
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_EXT_WAKE_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_o != 3'd0 && ext_wake_i) |=> (state_o == 3'd0)); // R8

    AST_IDLE_DROP_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_o != 3'd0 && !cpu_idle_i) |=> (state_o == 3'd0)); // R11

    AST_CLK_NESTING: assert property (@(posedge clk) disable iff (rst)
        main_clk_stop_o |-> core_clk_stop_o); // R2

    AST_ONE_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(state_o) != 3'd0 && state_o != 3'd0 && state_o != $past(state_o))
        |-> (state_o == $past(state_o) + 3'd1)); // R4

    AST_GATE_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        (past_ok && state_o != $past(state_o) && state_o >= 3'd3) |-> $past(pg_ack_i)); // R5

    AST_BUSY_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        wake_busy_o |=> (state_o == 3'd0)); // R10

endmodule

bind sleep_ctl sleep_ctl_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .cpu_idle_i      (cpu_idle_i),
    .ext_wake_i      (ext_wake_i),
    .pg_ack_i        (pg_ack_i),
    .state_o         (state_o),
    .core_clk_stop_o (core_clk_stop_o),
    .main_clk_stop_o (main_clk_stop_o),
    .wake_busy_o     (wake_busy_o)
);

// File: tb/sleep_ctl_bench.sv
module sleep_ctl_bench;

    localparam int CNT_W = 16;
    localparam int N_IRQ = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cpu_idle = 1'b0;
    logic             pred_mode = 1'b0;
    logic             hint_valid = 1'b0;
    logic [CNT_W-1:0] hint = '0;
    logic [CNT_W-1:0] tmo [3];
    logic [CNT_W-1:0] lat [4];
    logic [N_IRQ-1:0] irq = '0;
    logic [N_IRQ-1:0] irq_en = '0;
    logic             tmr_wake = 1'b0;
    logic             ext_wake = 1'b0;
    logic             pg_ack = 1'b0;

    logic [2:0] state_o;
    logic       core_clk_stop_o, main_clk_stop_o, pwr_gate_req_o, wake_busy_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sleep_ctl #(.CNT_W(CNT_W), .N_IRQ(N_IRQ)) u_sleep_ctl (
        .clk             (clk),
        .rst             (rst),
        .cpu_idle_i      (cpu_idle),
        .pred_mode_i     (pred_mode),
        .hint_valid_i    (hint_valid),
        .hint_cycles_i   (hint),
        .tmo_cfg_i       ({tmo[2], tmo[1], tmo[0]}),
        .lat_cfg_i       ({lat[3], lat[2], lat[1], lat[0]}),
        .irq_i           (irq),
        .irq_en_i        (irq_en),
        .tmr_wake_i      (tmr_wake),
        .ext_wake_i      (ext_wake),
        .pg_ack_i        (pg_ack),
        .state_o         (state_o),
        .core_clk_stop_o (core_clk_stop_o),
        .main_clk_stop_o (main_clk_stop_o),
        .pwr_gate_req_o  (pwr_gate_req_o),
        .wake_busy_o     (wake_busy_o)
    );

    function automatic int eff_tmo(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    // deepest level whose latency fits the hint, 0 when none
    function automatic int pick_depth(input int h);
        int r = 0;
        for (int k = 0; k < 4; k++) if (int'(lat[k]) <= h) r = k + 1;
        return r;
    endfunction

    function automatic int lat_of(input int st);
        return int'(lat[st-1]);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_eq(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag, input int st, input bit pend, input bit busy);
        expect_eq(tag, "state", int'(state_o), st);
        expect_eq(tag, "core_clk_stop", int'(core_clk_stop_o), int'(st != 0));
        expect_eq(tag, "main_clk_stop", int'(main_clk_stop_o), int'(st >= 2));
        expect_eq(tag, "pwr_gate_req", int'(pwr_gate_req_o), int'((st >= 3) || pend));
        expect_eq(tag, "wake_busy", int'(wake_busy_o), int'(busy));
    endtask

    task automatic go_active();
        cpu_idle   = 1'b0;
        pred_mode  = 1'b0;
        hint_valid = 1'b0;
        irq = '0; tmr_wake = 1'b0; ext_wake = 1'b0; pg_ack = 1'b0;
        tick();
        while (wake_busy_o) tick();
        tick();
    endtask

    task automatic ack_pulse();
        pg_ack = 1'b1;
        tick();
        pg_ack = 1'b0;
    endtask

    task automatic run_timeout_chain();
        for (int k = 0; k < 3; k++) tmo[k] = CNT_W'($urandom_range(0, 12));
        for (int k = 0; k < 4; k++) lat[k] = CNT_W'($urandom_range(0, 9));
        irq_en = N_IRQ'($urandom_range(0, 15));
        pred_mode = 1'b0;
        cpu_idle  = 1'b1;
        tick();
        check_all("R3", 1, 1'b0, 1'b0);
        for (int i = 1; i < eff_tmo(int'(tmo[0])); i++) begin tick(); check_all("R4", 1, 1'b0, 1'b0); end
        tick(); check_all("R4", 2, 1'b0, 1'b0);
        for (int i = 1; i < eff_tmo(int'(tmo[1])); i++) begin tick(); check_all("R4", 2, 1'b0, 1'b0); end
        tick(); check_all("R5", 2, 1'b1, 1'b0);
        for (int i = 0; i < int'($urandom_range(0, 4)); i++) begin tick(); check_all("R5", 2, 1'b1, 1'b0); end
        ack_pulse(); check_all("R5", 3, 1'b0, 1'b0);
        for (int i = 1; i < eff_tmo(int'(tmo[2])); i++) begin tick(); check_all("R4", 3, 1'b0, 1'b0); end
        tick(); check_all("R5", 3, 1'b1, 1'b0);
        ack_pulse(); check_all("R5", 4, 1'b0, 1'b0);
        irq = '1; tmr_wake = 1'b1;
        for (int i = 0; i < 3; i++) begin tick(); check_all("R8", 4, 1'b0, 1'b0); end
        irq = '0; tmr_wake = 1'b0;
        ext_wake = 1'b1; tick(); ext_wake = 1'b0;
        for (int i = 0; i <= lat_of(4); i++) begin
            if (i > 0) tick();
            check_all("R10", 0, 1'b0, i < lat_of(4));
        end
        tick(); check_all("R10", 1, 1'b0, 1'b0);
        go_active();
    endtask

    task automatic run_predictive(input int h);
        int exp_st;
        exp_st = pick_depth(h);
        hint = CNT_W'(h);
        pred_mode = 1'b1; hint_valid = 1'b1;
        cpu_idle = 1'b1;
        tick();
        if (exp_st == 0) begin
            for (int i = 0; i < 4; i++) begin check_all("R6", 0, 1'b0, 1'b0); tick(); end
            go_active();
        end else begin
            if (exp_st >= 3) begin
                check_all("R6", 0, 1'b1, 1'b0);
                ack_pulse();
            end
            check_all("R6", exp_st, 1'b0, 1'b0);
            for (int i = 0; i < 6; i++) begin tick(); check_all("R6", exp_st, 1'b0, 1'b0); end
            cpu_idle = 1'b0;
            tick();
            check_all("R11", 0, 1'b0, lat_of(exp_st) > 0);
            for (int i = 1; i <= lat_of(exp_st); i++) begin
                tick(); check_all("R10", 0, 1'b0, i < lat_of(exp_st));
            end
            go_active();
        end
    endtask

    initial begin
        void'($urandom(32'd7919));
        for (int k = 0; k < 3; k++) tmo[k] = '0;
        for (int k = 0; k < 4; k++) lat[k] = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check_all("R1", 0, 1'b0, 1'b0);

        for (int n = 0; n < 6; n++) run_timeout_chain();

        // directed predictive boundaries
        tmo[0] = 16'd1; tmo[1] = 16'd1; tmo[2] = 16'd1;
        lat[0] = 16'd3; lat[1] = 16'd10; lat[2] = 16'd50; lat[3] = 16'd200;
        run_predictive(50);
        run_predictive(49);
        run_predictive(2);
        run_predictive(200);
        for (int n = 0; n < 10; n++) begin
            for (int k = 0; k < 3; k++) tmo[k] = CNT_W'($urandom_range(1, 3));
            for (int k = 0; k < 4; k++) lat[k] = CNT_W'($urandom_range(0, 40));
            run_predictive(int'($urandom_range(0, 40)));
        end

        // disabled interrupt lines are masked and keep the timer running
        tmo[0] = 16'd2; tmo[1] = 16'd8; tmo[2] = 16'd5;
        lat[0] = 16'd0; lat[1] = 16'd4; lat[2] = 16'd0; lat[3] = 16'd0;
        irq_en = 4'b0101;
        cpu_idle = 1'b1;
        tick(); check_all("R3", 1, 1'b0, 1'b0);
        tick(); check_all("R4", 1, 1'b0, 1'b0);
        tick(); check_all("R4", 2, 1'b0, 1'b0);
        irq = 4'b1010;
        for (int i = 3; i <= 9; i++) begin
            if (i == 5) irq = '0;
            tick(); check_all("R9", 2, 1'b0, 1'b0);
        end
        tick(); check_all("R9", 2, 1'b1, 1'b0);
        irq = 4'b0001; tick(); irq = '0;
        check_all("R7", 0, 1'b0, 1'b1);
        go_active();

        // timer wake from IDLE
        cpu_idle = 1'b1;
        tick(); check_all("R3", 1, 1'b0, 1'b0);
        tmr_wake = 1'b1; tick(); tmr_wake = 1'b0;
        check_all("R7", 0, 1'b0, 1'b0);
        go_active();

        // idle drop while a gated entry from ACTIVE is pending
        lat[0] = 16'd1; lat[1] = 16'd2; lat[2] = 16'd3; lat[3] = 16'd4;
        hint = 16'd100; pred_mode = 1'b1; hint_valid = 1'b1;
        cpu_idle = 1'b1;
        tick(); check_all("R6", 0, 1'b1, 1'b0);
        cpu_idle = 1'b0;
        tick(); check_all("R11", 0, 1'b0, 1'b0);
        go_active();

        // idle drop while STOP waits for the STANDBY acknowledge
        tmo[0] = 16'd1; tmo[1] = 16'd1;
        cpu_idle = 1'b1;
        tick(); check_all("R3", 1, 1'b0, 1'b0);
        tick(); check_all("R4", 2, 1'b0, 1'b0);
        tick(); check_all("R5", 2, 1'b1, 1'b0);
        cpu_idle = 1'b0;
        tick(); check_all("R11", 0, 1'b0, 1'b1);
        go_active();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL all-requirements watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule